// File: doc/BRIEF.md
# Xon/Xoff Software Flow Controller

This block handles in-band flow control for a single serial channel. It watches every character the receiver delivers and compares it with two programmable control characters: one that pauses the local transmitter and one that lets it continue. A paused transmitter is signalled through a hold flag. Recognized control characters are flagged for discard, so they do not go into the receive FIFO. A received pause character also produces a one-cycle event that an interrupt controller can enable separately.

The block also drives flow control toward the far end. It takes two 4-bit fields from a threshold register and multiplies each by four to get a stop level and a resume level. When the local receive FIFO fills to the stop level, the block asks the transmitter to insert the pause character. Once the FIFO drains to the resume level, it asks for the resume character. The request does not depend on the local hold flag, so a paused transmitter can still send a control character. An optional mode lets any received character end a pause.

Top module: `xonxoff_flow_ctl`

## Requirements
- R1: After reset, tx_hold, ins_req and xoff_evt are 0.
- R2: While sw_en is 1, a strobe whose rx_data equals xoff_char drives rx_discard to 1 in the strobe cycle. tx_hold reads 1 from the next cycle on, and xoff_evt is 1 for exactly that next cycle.
- R3: With xon_any 0, a strobe that equals xon_char clears tx_hold from the next cycle and is discarded. While held, any other character is not discarded and leaves tx_hold at 1.
- R4: With xon_any 1 and tx_hold 1, any character other than xoff_char clears tx_hold from the next cycle. The character is discarded only if it equals xon_char.
- R5: With xon_any 1 and tx_hold 0, a received xon_char is passed through as data (rx_discard 0). With xon_any 0 it is discarded.
- R6: Setting sw_en to 0 drops tx_hold in the same cycle and withdraws any insert request. While sw_en is 0, no discard, event or insert request is produced, and tx_hold stays 0 after sw_en returns to 1.
- R7: The stop level is 4×thr[3:0]. The pause request (ins_req 1, ins_data = xoff_char) rises the cycle after rx_level first reaches the stop level, and does not rise one byte below it.
- R8: After a pause has been requested, no second pause is requested while the level stays high. The resume request (ins_data = xon_char) rises the cycle after rx_level falls to 4×thr[7:4] or lower, and does not rise above it.
- R9: ins_req and ins_data stay constant until ins_ack is sampled high, and ins_req is 0 in the following cycle.
- R10: An insert request is raised even while tx_hold is 1.
- R11: thr[3:0] = 0 disables pause requests at any FIFO level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_en | input | 1 | Software flow control enable |
| xon_any | input | 1 | Any character ends a pause |
| xon_char | input | DATA_W | Resume control character |
| xoff_char | input | DATA_W | Pause control character |
| thr | input | 2×THR_FIELD_W | [3:0] stop level/4, [7:4] resume level/4 |
| rx_valid | input | 1 | Received character strobe |
| rx_data | input | DATA_W | Received character |
| rx_level | input | LVL_W | Receive FIFO fill level |
| ins_ack | input | 1 | Transmitter took the inserted character |
| tx_hold | output | 1 | Local transmitter must pause |
| ins_req | output | 1 | Insert control character request |
| ins_data | output | DATA_W | Character to insert |
| rx_discard | output | 1 | Current strobe is a control character, do not store |
| xoff_evt | output | 1 | One-cycle pause-received event |

## Verification
The bench puts the FIFO level exactly on the stop level, one byte below it, and one byte above the resume level. A comparison that is off by one or uses the wrong direction would request early, request late or never request. It covers both outcomes of the resume-character corner in any-character mode: the character is discarded while paused and passed through when not paused. A design that always discarded it would lose data, and one that never discarded it would store a control character. It also raises a request while the channel is paused, and disables the block with a request pending. A design that gated requests on the hold flag, or kept stale state after disable, would fail these checks.

// File: rtl/xfc_pkg.sv
package xfc_pkg;
   // far-end state as seen by the insert logic
   typedef enum logic {
      RMT_OPEN    = 1'b0,
      RMT_STOPPED = 1'b1
   } remote_e;
endpackage

// File: rtl/xfc_rx_decode.sv
module xfc_rx_decode #(
   parameter int DATA_W     = 8,
   parameter bit XON_ANY_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_en,
   input  logic              xon_any,
   input  logic [DATA_W-1:0] xon_char,
   input  logic [DATA_W-1:0] xoff_char,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_data,
   output logic              tx_hold,
   output logic              rx_discard,
   output logic              xoff_evt
);
   logic any_mode;
   logic hit_off, hit_on, any_go, resume;
   logic hold_q, evt_q;

   generate
      if (XON_ANY_EN) begin : g_any
         assign any_mode = xon_any;
      end else begin : g_no_any
         logic unused_any;
         assign unused_any = xon_any;
         assign any_mode   = 1'b0;
      end
   endgenerate

   always_comb begin
      hit_off = rx_valid && sw_en && (rx_data == xoff_char);
      hit_on  = rx_valid && sw_en && (rx_data == xon_char) && !hit_off;
      any_go  = rx_valid && sw_en && any_mode && hold_q && !hit_off;
      resume  = hold_q && (hit_on || any_go);
      // in any-character mode an unpaused resume char is plain data
      rx_discard = hit_off || (hit_on && !(any_mode && !hold_q));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= 1'b0;
         evt_q  <= 1'b0;
      end else begin
         evt_q <= hit_off;
         if (!sw_en)       hold_q <= 1'b0;
         else if (hit_off) hold_q <= 1'b1;
         else if (resume)  hold_q <= 1'b0;
      end
   end

   assign tx_hold  = hold_q && sw_en;
   assign xoff_evt = evt_q;
endmodule

// File: rtl/xfc_tx_insert.sv
module xfc_tx_insert
   import xfc_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int LVL_W       = 7,
   parameter int THR_FIELD_W = 4,
   parameter int SCALE_SH    = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     sw_en,
   input  logic [DATA_W-1:0]        xon_char,
   input  logic [DATA_W-1:0]        xoff_char,
   input  logic [2*THR_FIELD_W-1:0] thr,
   input  logic [LVL_W-1:0]         rx_level,
   input  logic                     ins_ack,
   output logic                     ins_req,
   output logic [DATA_W-1:0]        ins_data
);
   localparam int THR_LVL_W = THR_FIELD_W + SCALE_SH;
   localparam int CMP_W     = (LVL_W > THR_LVL_W) ? LVL_W : THR_LVL_W;

   logic [CMP_W-1:0] lvl_c, stop_c, go_c;
   logic             stop_en;
   remote_e          rmt_q;
   logic             req_q;
   logic [DATA_W-1:0] data_q;

   assign lvl_c   = CMP_W'(rx_level);
   assign stop_c  = CMP_W'({thr[THR_FIELD_W-1:0], {SCALE_SH{1'b0}}});
   assign go_c    = CMP_W'({thr[2*THR_FIELD_W-1:THR_FIELD_W], {SCALE_SH{1'b0}}});
   assign stop_en = (thr[THR_FIELD_W-1:0] != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rmt_q  <= RMT_OPEN;
         req_q  <= 1'b0;
         data_q <= '0;
      end else if (!sw_en) begin
         rmt_q <= RMT_OPEN;
         req_q <= 1'b0;
      end else if (req_q) begin
         if (ins_ack) req_q <= 1'b0;
      end else if (rmt_q == RMT_OPEN) begin
         if (stop_en && (lvl_c >= stop_c)) begin
            req_q  <= 1'b1;
            data_q <= xoff_char;
            rmt_q  <= RMT_STOPPED;
         end
      end else if (lvl_c <= go_c) begin
         req_q  <= 1'b1;
         data_q <= xon_char;
         rmt_q  <= RMT_OPEN;
      end
   end

   assign ins_req  = req_q;
   assign ins_data = data_q;
endmodule

// File: rtl/xonxoff_flow_ctl.sv
module xonxoff_flow_ctl #(
   parameter int DATA_W      = 8,
   parameter int LVL_W       = 7,
   parameter int THR_FIELD_W = 4,
   parameter int SCALE_SH    = 2,
   parameter bit XON_ANY_EN  = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     sw_en,
   input  logic                     xon_any,
   input  logic [DATA_W-1:0]        xon_char,
   input  logic [DATA_W-1:0]        xoff_char,
   input  logic [2*THR_FIELD_W-1:0] thr,
   input  logic                     rx_valid,
   input  logic [DATA_W-1:0]        rx_data,
   input  logic [LVL_W-1:0]         rx_level,
   input  logic                     ins_ack,
   output logic                     tx_hold,
   output logic                     ins_req,
   output logic [DATA_W-1:0]        ins_data,
   output logic                     rx_discard,
   output logic                     xoff_evt
);
   generate
      if (DATA_W < 5 || DATA_W > 16) begin : g_bad_data
         $error("xonxoff_flow_ctl: DATA_W out of range");
      end
      if (THR_FIELD_W < 1 || SCALE_SH < 0) begin : g_bad_thr
         $error("xonxoff_flow_ctl: threshold field shape invalid");
      end
      if (LVL_W < THR_FIELD_W + SCALE_SH) begin : g_bad_lvl
         $error("xonxoff_flow_ctl: LVL_W cannot reach the largest threshold");
      end
   endgenerate

   xfc_rx_decode #(
      .DATA_W    (DATA_W),
      .XON_ANY_EN(XON_ANY_EN)
   ) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .sw_en     (sw_en),
      .xon_any   (xon_any),
      .xon_char  (xon_char),
      .xoff_char (xoff_char),
      .rx_valid  (rx_valid),
      .rx_data   (rx_data),
      .tx_hold   (tx_hold),
      .rx_discard(rx_discard),
      .xoff_evt  (xoff_evt)
   );

   xfc_tx_insert #(
      .DATA_W     (DATA_W),
      .LVL_W      (LVL_W),
      .THR_FIELD_W(THR_FIELD_W),
      .SCALE_SH   (SCALE_SH)
   ) u_ins (
      .clk      (clk),
      .rst_n    (rst_n),
      .sw_en    (sw_en),
      .xon_char (xon_char),
      .xoff_char(xoff_char),
      .thr      (thr),
      .rx_level (rx_level),
      .ins_ack  (ins_ack),
      .ins_req  (ins_req),
      .ins_data (ins_data)
   );
endmodule

// File: rtl/xfc_checker.sv
module xfc_checker #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sw_en,
   input logic [DATA_W-1:0] xon_char,
   input logic [DATA_W-1:0] xoff_char,
   input logic              rx_valid,
   input logic [DATA_W-1:0] rx_data,
   input logic              ins_ack,
   input logic              tx_hold,
   input logic              ins_req,
   input logic [DATA_W-1:0] ins_data,
   input logic              rx_discard,
   input logic              xoff_evt
);
   AST_XOFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_en && rx_valid && rx_data == xoff_char) |=> (xoff_evt && (tx_hold || !sw_en))); // R2

   AST_XON_RESUMES: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_en && tx_hold && rx_valid && rx_data == xon_char && rx_data != xoff_char) |=> !tx_hold); // R3

   AST_OFF_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      !sw_en |=> !ins_req); // R6

   AST_OFF_NO_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
      rx_discard |-> (sw_en && rx_valid)); // R6

   AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_req && !ins_ack && sw_en) |=> (ins_req && $stable(ins_data))); // R9

   AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_req && ins_ack) |=> !ins_req); // R9
endmodule

bind xonxoff_flow_ctl xfc_checker #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sw_en     (sw_en),
   .xon_char  (xon_char),
   .xoff_char (xoff_char),
   .rx_valid  (rx_valid),
   .rx_data   (rx_data),
   .ins_ack   (ins_ack),
   .tx_hold   (tx_hold),
   .ins_req   (ins_req),
   .ins_data  (ins_data),
   .rx_discard(rx_discard),
   .xoff_evt  (xoff_evt)
);

// File: tb/tb_xonxoff_flow_ctl.sv
`timescale 1ns/100ps
module tb_xonxoff_flow_ctl;
   localparam logic [7:0] XON  = 8'h11;
   localparam logic [7:0] XOFF = 8'h13;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sw_en = 1'b0, xon_any = 1'b0, rx_valid = 1'b0, ins_ack = 1'b0;
   logic [7:0] xon_char = XON, xoff_char = XOFF, thr = 8'h00, rx_data = 8'h00;
   logic [6:0] rx_level = '0;
   logic       tx_hold, ins_req, rx_discard, xoff_evt;
   logic [7:0] ins_data;
   int         n_run = 0, n_fail = 0;
   bit         done = 1'b0;

   always #2.5 clk = ~clk;

   xonxoff_flow_ctl dut (
      .clk(clk), .rst_n(rst_n), .sw_en(sw_en), .xon_any(xon_any),
      .xon_char(xon_char), .xoff_char(xoff_char), .thr(thr),
      .rx_valid(rx_valid), .rx_data(rx_data), .rx_level(rx_level),
      .ins_ack(ins_ack), .tx_hold(tx_hold), .ins_req(ins_req),
      .ins_data(ins_data), .rx_discard(rx_discard), .xoff_evt(xoff_evt)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk); #1;
   endtask

   // strobe one character; check discard in-cycle, leave caller 1ns past the edge
   task automatic send(input logic [7:0] d, input int exp_disc, input string req);
      @(negedge clk);
      rx_valid = 1'b1; rx_data = d;
      #0.5 chk(req, rx_discard, exp_disc);
      @(posedge clk); #1;
      rx_valid = 1'b0;
   endtask

   task automatic set_level(input int l);
      @(negedge clk); rx_level = 7'(l);
   endtask

   task automatic ack();
      @(negedge clk); ins_ack = 1'b1;
      @(posedge clk); #1; ins_ack = 1'b0;
      chk("R9 drop after ack", ins_req, 0);
   endtask

   task automatic t_reset();
      #1;
      chk("R1 hold", tx_hold, 0);
      chk("R1 req", ins_req, 0);
      chk("R1 evt", xoff_evt, 0);
      rst_n = 1'b1;
      tick();
      sw_en = 1'b1;
   endtask

   task automatic t_basic();
      send(XOFF, 1, "R2 discard xoff");
      chk("R2 hold", tx_hold, 1);
      chk("R2 evt", xoff_evt, 1);
      tick();
      chk("R2 evt one cycle", xoff_evt, 0);
      send(8'h41, 0, "R3 data while held kept");
      chk("R3 still held", tx_hold, 1);
      send(XON, 1, "R3 discard xon");
      chk("R3 resumed", tx_hold, 0);
   endtask

   task automatic t_any();
      @(negedge clk); xon_any = 1'b1;
      send(XOFF, 1, "R4 pause");
      chk("R4 held", tx_hold, 1);
      send(8'h42, 0, "R4 any char kept");
      chk("R4 any char resumes", tx_hold, 0);
      send(XOFF, 1, "R4 pause again");
      send(XON, 1, "R4 xon discarded while held");
      chk("R4 xon resumes", tx_hold, 0);
      send(XON, 0, "R5 xon passes when not held");
      chk("R5 stays open", tx_hold, 0);
      @(negedge clk); xon_any = 1'b0;
      send(XON, 1, "R5 xon discarded in normal mode");
   endtask

   task automatic t_disable();
      send(XOFF, 1, "R6 pause");
      chk("R6 held", tx_hold, 1);
      @(negedge clk); sw_en = 1'b0;
      #0.5 chk("R6 hold drops at once", tx_hold, 0);
      send(XOFF, 0, "R6 no discard when off");
      chk("R6 no evt when off", xoff_evt, 0);
      @(negedge clk); sw_en = 1'b1;
      #0.5 chk("R6 hold stays clear", tx_hold, 0);
      tick();
   endtask

   task automatic t_thresh();
      @(negedge clk); thr = 8'h25;          // stop 20, resume 8
      set_level(19); tick(); tick();
      chk("R7 below stop", ins_req, 0);
      set_level(20); tick();
      chk("R7 req at stop", ins_req, 1);
      chk("R7 xoff data", ins_data, XOFF);
      tick(); tick();
      chk("R9 held without ack", ins_req, 1);
      chk("R9 data stable", ins_data, XOFF);
      ack();
      tick(); tick();
      chk("R8 no repeat pause", ins_req, 0);
      set_level(9); tick(); tick();
      chk("R8 above resume", ins_req, 0);
      set_level(8); tick();
      chk("R8 req at resume", ins_req, 1);
      chk("R8 xon data", ins_data, XON);
      ack();
   endtask

   task automatic t_held_insert();
      send(XOFF, 1, "R10 pause");
      set_level(24); tick();
      chk("R10 hold", tx_hold, 1);
      chk("R10 req while held", ins_req, 1);
      chk("R10 data", ins_data, XOFF);
      @(negedge clk); sw_en = 1'b0;
      @(posedge clk); #1;
      chk("R6 req withdrawn", ins_req, 0);
      tick();
      chk("R6 no req when off", ins_req, 0);
      set_level(0);
      @(negedge clk); sw_en = 1'b1;
      tick(); tick();
      chk("R6 clean after enable", ins_req, 0);
   endtask

   task automatic t_zero();
      @(negedge clk); thr = 8'h30;
      set_level(127); tick(); tick(); tick();
      chk("R11 zero stop disables", ins_req, 0);
      set_level(0); tick();
   endtask

   initial begin
      t_reset();
      t_basic();
      t_any();
      t_disable();
      t_thresh();
      t_held_insert();
      t_zero();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule